// File: doc/BRIEF.md
# Counter-Driven Fractional Modulus Controller for FSK

This block sets the divide ratio of a two-modulus (N / N+1) prescaler inside a phase-locked synthesizer. A binary up-counter runs from the reference clock. When it reaches its top value it raises a carry, and on the next edge it reloads a programmed start word. The least significant counter bit drives the prescaler's modulus-select line. Over one counter cycle that bit spends a fixed share of its states low. This share is the fractional part of the average divide ratio.

Two start words are supplied, one for mark and one for space. The data bit picks between them only at the reload edge, so each counter cycle uses one word from start to end. No correction is ever needed. The data may therefore stay at one level for as long as the application wants, and the output frequency stays exact down to DC. Typical odd words that differ in one upper bit (for example 5 and 7 on a 4-bit counter) give ratios of 5/11 and 4/9.

The reset input is asynchronous and active low, and it is released through an internal two-stage synchronizer. The first word is loaded on the edge that follows the synchronized release.

Top module: `fsk_frac_modctl`

## Requirements
- R1: While reset is applied, and for the two clock edges after rst_n rises, modctl_o and carry_o are 0. The third edge after release loads the word selected by data_i.
- R2: Between reloads the counter advances by one on each edge, so modctl_o toggles on every edge inside a cycle. The state at offset k after a load of word s has modctl_o = (s + k) mod 2.
- R3: carry_o is 1 exactly when the counter holds all ones (15 for the default 4-bit width).
- R4: On the edge after carry_o is 1, the counter loads the word selected by data_i as it is seen at that edge. Changes to data_i, mark_word_i or space_word_i at any other time have no effect on the running cycle.
- R5: The span from one load through the next carry state is 2^W − s states, where s is the loaded word (11 for s=5, 9 for s=7, 16 for s=0, 1 for s=15).
- R6: In a cycle started from word s, modctl_o is low in as many states as there are even values in [s, 2^W−1]. That is (2^W − s − 1)/2 for odd s (5 of 11 for s=5, 4 of 9 for s=7) and (2^W − s)/2 for even s. For odd s, modctl_o stays high across the carry-to-reload edge.
- R7: data_i = 1 selects mark_word_i and data_i = 0 selects space_word_i. A constant data level repeats the same cycle with no limit.
- R8: Low on modctl_o asks the prescaler for N+1 and high asks for N. A cycle of L states from word s therefore costs N·L + (low count) output periods, which gives an average ratio of N + lows/L (about 128.454 and 128.444 for N=128 with words 5 and 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_i | input | 1 | FSK data bit: 1 picks the mark word, 0 the space word |
| mark_word_i | input | W (4) | Start word loaded for a mark cycle |
| space_word_i | input | W (4) | Start word loaded for a space cycle |
| modctl_o | output | 1 | Modulus select to the prescaler (counter bit 0) |
| carry_o | output | 1 | High while the counter holds all ones |

## Verification
Both outputs come straight from the counter register, so each one changes on the edge after its cause. After reset release, the two synchronizer edges come first, the load follows on the third edge, and the first carry is due 15 − s edges after that. The directed reset sequence checks both outputs at every one of those edges. In the steady state, the word that governs a cycle is fixed by data_i at the negative edge where carry_o is seen high. The bench changes stimulus just after a positive edge and samples only at negative edges. Its cycle monitor takes the word at each carry, checks the parity of every state, and checks the cycle length, the low count and the prescaler cycle sum when the next carry appears.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  // Default counter width for the modulus controller
  localparam int unsigned FMC_WIDTH_DEF = 4;

  // Observed counter status handed from the counter core to the top
  typedef struct packed {
    logic primed;  // a start word has been loaded since reset
    logic carry;   // counter at its top value
    logic lsb;     // counter bit 0
  } fmc_status_t;

endpackage

// File: rtl/fmc_rst_sync.sv
module fmc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/fmc_word_sel.sv
module fmc_word_sel #(
  parameter int unsigned W = 4
) (
  input  logic         data_i,
  input  logic [W-1:0] mark_word_i,
  input  logic [W-1:0] space_word_i,
  output logic [W-1:0] word_o
);

  always_comb begin
    if (data_i) begin
      word_o = mark_word_i;
    end else begin
      word_o = space_word_i;
    end
  end

endmodule

// File: rtl/fmc_reload_ctr.sv
module fmc_reload_ctr
  import fmc_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [W-1:0] load_word_i,
  output fmc_status_t  stat_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         pend_q, pend_d;
  logic         cnt_en;
  logic         top;
  logic         reload;

  assign top    = ~pend_q & (&cnt_q);
  assign reload = pend_q | top;
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (cnt_en) begin
      pend_d = 1'b0;
      if (reload) begin
        cnt_d = load_word_i;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign stat_o.primed = ~pend_q;
  assign stat_o.carry  = top;
  assign stat_o.lsb    = cnt_q[0];

  // R1
  prime_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    pend_q |=> (!pend_q && cnt_q == $past(load_word_i)));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!pend_q && !top) |=> (cnt_q == $past(cnt_q) + ONE));

  // R4
  reload_word_chk: assert property (@(posedge clk) disable iff (!srst_n)
    top |=> (cnt_q == $past(load_word_i)));

endmodule

// File: rtl/fsk_frac_modctl.sv
module fsk_frac_modctl
  import fmc_pkg::*;
#(
  parameter int unsigned W         = FMC_WIDTH_DEF,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_i,
  input  logic [W-1:0] mark_word_i,
  input  logic [W-1:0] space_word_i,
  output logic         modctl_o,
  output logic         carry_o
);

  logic         srst_n;
  logic [W-1:0] sel_word;
  fmc_status_t  stat;

  fmc_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fmc_word_sel #(.W(W)) u_word_sel (
    .data_i       (data_i),
    .mark_word_i  (mark_word_i),
    .space_word_i (space_word_i),
    .word_o       (sel_word)
  );

  fmc_reload_ctr #(.W(W)) u_ctr (
    .clk         (clk),
    .srst_n      (srst_n),
    .load_word_i (sel_word),
    .stat_o      (stat)
  );

  assign modctl_o = stat.lsb;
  assign carry_o  = stat.carry;

  // R2
  toggle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (stat.primed && !carry_o) |=> (modctl_o != $past(modctl_o)));

  // R7
  select_chk: assert property (@(posedge clk) disable iff (!srst_n)
    carry_o |=> (modctl_o == ($past(data_i) ? $past(mark_word_i[0])
                                            : $past(space_word_i[0]))));

  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !stat.primed |-> (!modctl_o && !carry_o));

endmodule

// File: tb/test_fsk_frac_modctl.sv
module test_fsk_frac_modctl;

  localparam int W     = 4;
  localparam int TOPV  = 15;
  localparam int NBASE = 128;

  logic         clk;
  logic         rst_n;
  logic         data;
  logic [W-1:0] mark_w;
  logic [W-1:0] space_w;
  logic         modctl;
  logic         carry;

  int errors = 0;
  int checks = 0;

  fsk_frac_modctl #(.W(W)) i_fsk_frac_modctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_i       (data),
    .mark_word_i  (mark_w),
    .space_word_i (space_w),
    .modctl_o     (modctl),
    .carry_o      (carry)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int lows_of(int s);
    int n = 0;
    for (int v = s; v <= TOPV; v++) if ((v % 2) == 0) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Cycle monitor: word taken at each carry, cycle checked at next carry
  bit     armed = 0;
  int     cur_s, st_cnt, low_cnt, par_bad;
  longint div_sum, tot_div = 0, tot_exp = 0;
  int     cycles_done = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      armed = 0;
    end else if (!armed) begin
      if (carry) begin
        armed = 1; cur_s = data ? mark_w : space_w;
        st_cnt = 0; low_cnt = 0; par_bad = 0; div_sum = 0;
      end
    end else begin
      if (modctl != ((cur_s + st_cnt) % 2)) par_bad++;
      if (!modctl) low_cnt++;
      div_sum += modctl ? NBASE : NBASE + 1;
      st_cnt++;
      if (carry) begin
        chk(st_cnt == TOPV + 1 - cur_s, "R4 R5", "cycle length", st_cnt, TOPV + 1 - cur_s);
        chk(low_cnt == lows_of(cur_s), "R6", "low states", low_cnt, lows_of(cur_s));
        chk(par_bad == 0, "R2", "parity misses", par_bad, 0);
        chk(div_sum == NBASE * (TOPV + 1 - cur_s) + lows_of(cur_s), "R8", "prescaler sum",
            div_sum, NBASE * (TOPV + 1 - cur_s) + lows_of(cur_s));
        tot_div += div_sum;
        tot_exp += NBASE * (TOPV + 1 - cur_s) + lows_of(cur_s);
        cycles_done++;
        cur_s = data ? mark_w : space_w;
        st_cnt = 0; low_cnt = 0; par_bad = 0; div_sum = 0;
      end
    end
  end

  // Reset release and first cycle, edge by edge
  task automatic release_and_prime();
    int s;
    int last;
    @(negedge clk);
    s = data ? mark_w : space_w;
    last = 3 + TOPV - s;
    rst_n = 1'b1;
    for (int e = 1; e <= last; e++) begin
      @(negedge clk);
      chk(modctl == ((e < 3) ? 0 : ((s + e - 3) % 2)), "R1", "modctl after release",
          modctl, (e < 3) ? 0 : ((s + e - 3) % 2));
      chk(carry == (e == last), "R3", "carry after release", carry, (e == last));
    end
  endtask

  task automatic drive_random(input int clocks, input int p_flip, input bit words_too);
    for (int i = 0; i < clocks; i++) begin
      @(posedge clk); #1;
      if (($urandom % 100) < p_flip) data = ~data;
      if (words_too && (($urandom % 100) < 2)) begin
        mark_w  = W'($urandom);
        space_w = W'($urandom);
      end
    end
  endtask

  task automatic dc_run(input bit lvl, input int ncyc);
    int s;
    int clocks;
    int seen;
    @(posedge clk); #1; data = lvl;
    // wait for a carry so all counted cycles use the held level
    @(negedge clk);
    while (!carry) @(negedge clk);
    s = lvl ? mark_w : space_w;
    clocks = 0; seen = 0;
    while (seen < ncyc) begin
      @(negedge clk); clocks++;
      if (carry) seen++;
    end
    chk(clocks == ncyc * (TOPV + 1 - s), "R7", "DC period total", clocks, ncyc * (TOPV + 1 - s));
  endtask

  initial begin
    void'($urandom(32'd20515));
    rst_n = 1'b0; data = 1'b0; mark_w = 4'd7; space_w = 4'd5;
    repeat (3) @(negedge clk);
    chk(modctl == 1'b0, "R1", "modctl in reset", modctl, 0);
    chk(carry == 1'b0, "R1", "carry in reset", carry, 0);

    release_and_prime();          // space word 5
    dc_run(1'b0, 100);            // R7 space held
    dc_run(1'b1, 100);            // R7 mark held

    drive_random(8000, 30, 1'b0); // R4 data changes mid cycle

    // corner words: 0 and 15, new reset while running
    @(posedge clk); #1; rst_n = 1'b0; mark_w = 4'd15; space_w = 4'd0; data = 1'b0;
    repeat (2) @(negedge clk);
    chk(carry == 1'b0, "R1", "carry in second reset", carry, 0);
    release_and_prime();          // word 0, first carry 18 edges on
    dc_run(1'b1, 40);             // word 15: one-state cycles
    dc_run(1'b0, 20);
    drive_random(4000, 20, 1'b0);

    // random words and data
    mark_w = 4'd9; space_w = 4'd11;
    drive_random(20000, 15, 1'b1);
    @(negedge clk);

    chk(cycles_done > 1000, "R5", "cycles observed", cycles_done, 1000);
    chk(tot_div == tot_exp, "R8", "long-run prescaler total", tot_div, tot_exp);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule